// File: doc/BRIEF.md
# Wireless MAC Timing Parameter Generator

This block derives the three inter-frame timing values a wireless MAC needs, namely the slot time, the ACK timeout and the CTS timeout. It derives them from the PHY mode flags and a coverage class number. The coverage class lengthens the slot to allow for longer propagation distance. Each value is first formed in microseconds. It is then scaled into core clock cycles by multiplying by the core clock rate in MHz.

Each scaled value is loaded into its own output register when the update strobe is sampled high. A value that does not fit its register field is refused: that register keeps its previous contents, and a one-cycle error flag is raised. Each field decides on its own, so a refusal in one field does not stop the others from loading.

Top module: `mac_timing_gen`

## Requirements
- R1: While rst_ni is low and after its release, slot_cyc_o, ack_cyc_o, cts_cyc_o and err_o are all zero until the first update.
- R2: The base slot time is 6 us when turbo_i is 1, else 20 us when cck_i is 1, else 9 us. Turbo takes precedence over CCK.
- R3: The base SIFS is 8 us when turbo_i is 1, else 16 us when band5_i is 1, else 10 us. Turbo takes precedence over the 5 GHz flag.
- R4: The slot time in us is the base slot time plus 3 times cls_i. slot_cyc_o is that value multiplied by clk_mhz_i.
- R5: The ACK timeout in us is the base SIFS plus the slot time from R4. ack_cyc_o is that value multiplied by clk_mhz_i.
- R6: The CTS timeout equals the ACK timeout, and cts_cyc_o is loaded with the same cycle count as ack_cyc_o.
- R7: The new values appear on the outputs after the rising edge that samples upd_i high. While upd_i is low, the outputs hold and changes on the other inputs have no effect.
- R8: A field whose cycle count exceeds its register range keeps its old value. The ranges are 16 bits (max 65535) for slot_cyc_o and 14 bits (max 16383) for ack_cyc_o and cts_cyc_o. A count equal to the maximum is loaded. Every other field loads normally.
- R9: err_o is high for exactly the one cycle after an update in which at least one field was refused, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Update strobe; loads the registers on the edge that samples it high |
| turbo_i | input | 1 | Turbo mode flag |
| cck_i | input | 1 | CCK (11b) mode flag |
| band5_i | input | 1 | 5 GHz band flag |
| cls_i | input | 8 | Coverage class |
| clk_mhz_i | input | 8 | Core clock rate in MHz |
| slot_cyc_o | output | 16 | Slot time in cycles |
| ack_cyc_o | output | 14 | ACK timeout in cycles |
| cts_cyc_o | output | 14 | CTS timeout in cycles |
| err_o | output | 1 | One-cycle refusal flag |

## Verification
Every output is due one register stage after the strobe. The inputs change on the falling edge together with upd_i. The rising edge then loads the three fields and the error flag. The bench therefore compares all four results on the following falling edge.

The bench also changes the inputs to fresh values while upd_i is low. On the next falling edge it confirms that err_o has dropped and that the three fields still hold their previous contents.

// File: rtl/mac_timing_pkg.sv
package mac_timing_pkg;
  localparam int DEF_W = 6;
  localparam logic [DEF_W-1:0] SLOT_TURBO_US = 6'd6;
  localparam logic [DEF_W-1:0] SLOT_CCK_US   = 6'd20;
  localparam logic [DEF_W-1:0] SLOT_OFDM_US  = 6'd9;
  localparam logic [DEF_W-1:0] SIFS_TURBO_US = 6'd8;
  localparam logic [DEF_W-1:0] SIFS_5G_US    = 6'd16;
  localparam logic [DEF_W-1:0] SIFS_2G_US    = 6'd10;

  typedef struct packed {
    logic turbo;
    logic cck;
    logic band5;
  } phy_mode_t;
endpackage

// File: rtl/mac_timing_defaults.sv
module mac_timing_defaults
  import mac_timing_pkg::*;
(
  input  phy_mode_t        mode_i,
  output logic [DEF_W-1:0] slot_us_o,
  output logic [DEF_W-1:0] sifs_us_o
);
  // turbo wins over every other flag
  always_comb begin
    if (mode_i.turbo)    slot_us_o = SLOT_TURBO_US;
    else if (mode_i.cck) slot_us_o = SLOT_CCK_US;
    else                 slot_us_o = SLOT_OFDM_US;
  end

  always_comb begin
    if (mode_i.turbo)      sifs_us_o = SIFS_TURBO_US;
    else if (mode_i.band5) sifs_us_o = SIFS_5G_US;
    else                   sifs_us_o = SIFS_2G_US;
  end
endmodule

// File: rtl/mac_timing_calc.sv
module mac_timing_calc
  import mac_timing_pkg::*;
#(
  parameter int CLASS_W = 8,
  parameter int US_W    = CLASS_W + 6
) (
  input  logic [DEF_W-1:0]   slot_def_i,
  input  logic [DEF_W-1:0]   sifs_def_i,
  input  logic [CLASS_W-1:0] cls_i,
  output logic [US_W-1:0]    slot_us_o,
  output logic [US_W-1:0]    ack_us_o,
  output logic [US_W-1:0]    cts_us_o
);
  logic [US_W-1:0] cls_x3;

  assign cls_x3    = (US_W'(cls_i) << 1) + US_W'(cls_i);
  assign slot_us_o = US_W'(slot_def_i) + cls_x3;
  assign ack_us_o  = US_W'(sifs_def_i) + slot_us_o;
  assign cts_us_o  = ack_us_o;
endmodule

// File: rtl/mac_timing_field.sv
module mac_timing_field #(
  parameter int US_W    = 14,
  parameter int MHZ_W   = 8,
  parameter int FIELD_W = 16,
  parameter int CYC_W   = US_W + MHZ_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [US_W-1:0]    us_i,
  input  logic [MHZ_W-1:0]   mhz_i,
  output logic [FIELD_W-1:0] val_o,
  output logic               reject_o
);
  localparam logic [CYC_W:0] LIMIT = (CYC_W + 1)'(1) << FIELD_W;

  logic [CYC_W-1:0]   cyc;
  logic [FIELD_W-1:0] val_q;

  assign cyc      = CYC_W'(us_i) * CYC_W'(mhz_i);
  assign reject_o = {1'b0, cyc} >= LIMIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 val_q <= '0;
    else if (upd_i && !reject_o) val_q <= cyc[FIELD_W-1:0];
  end

  assign val_o = val_q;

  assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !reject_o) |=> (val_q == $past(cyc[FIELD_W-1:0])));
  assert_keep_on_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && reject_o) |=> $stable(val_q));
  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(val_q));
endmodule

// File: rtl/mac_timing_gen.sv
module mac_timing_gen
  import mac_timing_pkg::*;
#(
  parameter int CLASS_W = 8,
  parameter int MHZ_W   = 8,
  parameter int SLOT_W  = 16,
  parameter int ACK_W   = 14,
  parameter int CTS_W   = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               turbo_i,
  input  logic               cck_i,
  input  logic               band5_i,
  input  logic [CLASS_W-1:0] cls_i,
  input  logic [MHZ_W-1:0]   clk_mhz_i,
  output logic [SLOT_W-1:0]  slot_cyc_o,
  output logic [ACK_W-1:0]   ack_cyc_o,
  output logic [CTS_W-1:0]   cts_cyc_o,
  output logic               err_o
);
  localparam int US_W = CLASS_W + 6;

  phy_mode_t        mode;
  logic [DEF_W-1:0] slot_def, sifs_def;
  logic [US_W-1:0]  slot_us, ack_us, cts_us;
  logic             rej_slot, rej_ack, rej_cts;
  logic             err_q;

  assign mode = '{turbo: turbo_i, cck: cck_i, band5: band5_i};

  mac_timing_defaults u_defaults (
    .mode_i    (mode),
    .slot_us_o (slot_def),
    .sifs_us_o (sifs_def)
  );

  mac_timing_calc #(.CLASS_W(CLASS_W), .US_W(US_W)) u_calc (
    .slot_def_i (slot_def),
    .sifs_def_i (sifs_def),
    .cls_i      (cls_i),
    .slot_us_o  (slot_us),
    .ack_us_o   (ack_us),
    .cts_us_o   (cts_us)
  );

  mac_timing_field #(.US_W(US_W), .MHZ_W(MHZ_W), .FIELD_W(SLOT_W)) u_slot (
    .clk_i (clk_i), .rst_ni (rst_ni), .upd_i (upd_i),
    .us_i (slot_us), .mhz_i (clk_mhz_i),
    .val_o (slot_cyc_o), .reject_o (rej_slot)
  );

  mac_timing_field #(.US_W(US_W), .MHZ_W(MHZ_W), .FIELD_W(ACK_W)) u_ack (
    .clk_i (clk_i), .rst_ni (rst_ni), .upd_i (upd_i),
    .us_i (ack_us), .mhz_i (clk_mhz_i),
    .val_o (ack_cyc_o), .reject_o (rej_ack)
  );

  mac_timing_field #(.US_W(US_W), .MHZ_W(MHZ_W), .FIELD_W(CTS_W)) u_cts (
    .clk_i (clk_i), .rst_ni (rst_ni), .upd_i (upd_i),
    .us_i (cts_us), .mhz_i (clk_mhz_i),
    .val_o (cts_cyc_o), .reject_o (rej_cts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= upd_i && (rej_slot || rej_ack || rej_cts);
  end

  assign err_o = err_q;

  assert_err_after_upd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(upd_i));
  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> !err_o);
  assert_ack_past_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_us >= slot_us + US_W'(8));
  assert_cts_tracks_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !rej_ack && !rej_cts) |=> (32'(cts_cyc_o) == 32'(ack_cyc_o)));
endmodule

// File: tb/mac_timing_gen_tb.sv
module mac_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0, turbo = 1'b0, cck = 1'b0, band5 = 1'b0;
  logic [7:0]  cls = '0, mhz = '0;
  logic [15:0] slot_o;
  logic [13:0] ack_o, cts_o;
  logic        err_o;

  int n_chk = 0, n_bad = 0;
  int m_slot = 0, m_ack = 0, m_cts = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mac_timing_gen u_dut (
    .clk_i (clk), .rst_ni (rst_n), .upd_i (upd),
    .turbo_i (turbo), .cck_i (cck), .band5_i (band5),
    .cls_i (cls), .clk_mhz_i (mhz),
    .slot_cyc_o (slot_o), .ack_cyc_o (ack_o), .cts_cyc_o (cts_o), .err_o (err_o)
  );

  function automatic int def_slot(bit t, bit c);
    return t ? 6 : (c ? 20 : 9);
  endfunction
  function automatic int def_sifs(bit t, bit b);
    return t ? 8 : (b ? 16 : 10);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2..R9: one update, check one cycle later, then an idle cycle with fresh inputs
  task automatic apply(bit t, bit c, bit b, int cc, int mz);
    int s_us, a_us, s_cy, a_cy, e_err;
    s_us = def_slot(t, c) + 3 * cc;
    a_us = def_sifs(t, b) + s_us;
    s_cy = s_us * mz;
    a_cy = a_us * mz;
    e_err = 0;
    if (s_cy <= 65535) m_slot = s_cy; else e_err = 1;
    if (a_cy <= 16383) begin m_ack = a_cy; m_cts = a_cy; end else e_err = 1;
    @(negedge clk);
    turbo = t; cck = c; band5 = b; cls = 8'(cc); mhz = 8'(mz); upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    turbo = 1'($urandom); cck = 1'($urandom); band5 = 1'($urandom);
    cls = 8'($urandom); mhz = 8'($urandom);
    check("R4/R8 slot", int'(slot_o), m_slot);
    check("R5/R8 ack", int'(ack_o), m_ack);
    check("R6 cts", int'(cts_o), m_cts);
    check("R9 err pulse", int'(err_o), e_err);
    @(negedge clk);
    check("R9 err drop", int'(err_o), 0);
    check("R7 hold slot", int'(slot_o), m_slot);
    check("R7 hold ack", int'(ack_o), m_ack);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 slot", int'(slot_o), 0);
    check("R1 err", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 slot after release", int'(slot_o), 0);
    check("R1 ack after release", int'(ack_o), 0);
    check("R1 cts after release", int'(cts_o), 0);
    apply(1, 1, 1, 0, 40);    // R2 R3 turbo priority: 240 / 560
    apply(0, 1, 0, 0, 40);    // R2 cck: 800 / 1200
    apply(0, 0, 1, 0, 40);    // R3 5 GHz: 360 / 1000
    apply(0, 1, 1, 0, 40);    // cck + 5 GHz: 36 us ack
    apply(0, 0, 0, 0, 40);    // plain OFDM 2.4 GHz
    apply(0, 0, 0, 5, 10);    // R4 class scaling
    apply(0, 1, 0, 79, 255);  // R8 slot exactly 65535, ack refused
    apply(0, 0, 0, 36, 129);  // R8 ack exactly 16383
    apply(0, 0, 0, 36, 130);  // R8 ack refused, slot loads
    apply(0, 1, 1, 255, 255); // R8 all refused
    apply(1, 0, 0, 0, 0);     // zero clock rate
    for (int i = 0; i < 80; i++)
      apply(1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule